// File: doc/BRIEF.md
# Queue Status and Interrupt Unit

This block turns the occupancy of sixty-four hardware queues into condition flags and interrupt requests. For every queue it receives the current fill level, a capacity code and two watermark codes. From these it derives empty, nearly-empty, nearly-full and full conditions. The flags are packed into read-only status words on a small register port.

The sixty-four queues form two banks of thirty-two. A lower-bank queue has all four flags visible, and software picks which of them, or its inverse, raises that queue's interrupt. An upper-bank queue shows only its nearly-empty and full flags, and its interrupt condition is always nearly-empty. Each bank has an enable mask and a pending word. A pending bit is latched on a rising edge of its queue's condition while the enable bit is set. Software clears pending bits by writing ones to them. Each bank drives one interrupt line that is high while any of its pending bits is set.

Top module: `qstat_irq`

## Requirements
- R1: The lower-bank status words are at word addresses 0 to 3. Word k holds queues 8k to 8k+7, and queue q uses the nibble at bits 4*(q mod 8). In that nibble, bit 0 is empty, bit 1 is nearly empty, bit 2 is nearly full and bit 3 is full.
- R2: The capacity of a queue is 16 shifted left by its 2-bit size code (16, 32, 64 or 128 entries). Empty is set when occupancy is 0. Full is set when occupancy is at least the capacity.
- R3: A 3-bit watermark code decodes to a threshold: code 0 gives 0, and code c > 0 gives 2^(c-1). Nearly empty is set when occupancy is at most the NE threshold. Nearly full is set when the free space (capacity minus occupancy, floored at 0) is at most the NF threshold.
- R4: Word address 4 holds the nearly-empty flags of queues 32 to 63, and word address 5 holds their full flags, at bit q-32.
- R5: Source-select words at addresses 10 to 13 hold 4-bit fields, eight queues to a word, in the same positions as R1. Field bits [1:0] choose the flag: 0 empty, 1 nearly empty, 2 nearly full, 3 full. Field bit 2 inverts the choice. Field bit 3 is not writable and reads 0 in every field, queue 0's included.
- R6: The interrupt condition of every upper-bank queue is its nearly-empty flag, regardless of any source-select write.
- R7: Pending bit q of a bank is set on the first clock edge at which the queue's condition is high after being low at the previous edge, and only if enable bit q (address 8 for the lower bank, 9 for the upper bank) is 1 at that edge. It is readable after that edge.
- R8: Pending words are at address 6 (lower bank) and address 7 (upper bank). Writing a 1 to a bit clears it and writing a 0 leaves it. A set that occurs in the same cycle as a clear wins, so writing back a value read earlier clears exactly the bits that were seen.
- R9: irq_lo_o is high exactly while pending word 6 is nonzero, and irq_hi_o is high exactly while pending word 7 is nonzero.
- R10: After reset, the enable, source-select and pending registers read 0 and both interrupt lines are low.
- R11: Writes to the status addresses 0 to 5 have no effect. Clearing an enable bit leaves an already pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| occ_i | input | 512 | Occupancy per queue, 8 bits each, queue q at bits 8q+7:8q |
| size_i | input | 128 | Capacity code per queue, 2 bits each |
| ne_wm_i | input | 192 | Nearly-empty watermark code per queue, 3 bits each |
| nf_wm_i | input | 192 | Nearly-full watermark code per queue, 3 bits each |
| reg_we_i | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_lo_o | output | 1 | Interrupt line for queues 0 to 31 |
| irq_hi_o | output | 1 | Interrupt line for queues 32 to 63 |

## Verification
Status words follow the queue inputs combinationally, so they are due in the same cycle. The bench reads them after the inputs settle, with no clock edge in between. Pending bits and both interrupt lines change one edge after the condition edge or the clearing write. The bench therefore advances exactly one edge through a single task, which updates its reference pending words at that edge and compares them after it. Enable and source-select writes also take effect at that edge. The reference therefore computes the conditions of that edge from the values held before the write.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
  localparam int OCC_W      = 8;
  localparam int SZ_W       = 2;
  localparam int WM_W       = 3;
  localparam int SEL_W      = 3;
  localparam int FIELD_W    = 4;
  localparam int Q_PER_WORD = 8;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic full;
    logic nfull;
    logic nempty;
    logic empty;
  } qflags_t;

  typedef enum logic [1:0] {
    SRC_EMPTY  = 2'd0,
    SRC_NEMPTY = 2'd1,
    SRC_NFULL  = 2'd2,
    SRC_FULL   = 2'd3
  } src_e;

  function automatic logic [OCC_W-1:0] wm_thresh(input logic [WM_W-1:0] code);
    if (code == '0) return '0;
    return {{(OCC_W-1){1'b0}}, 1'b1} << (code - WM_W'(1));
  endfunction

  function automatic logic [OCC_W-1:0] cap_entries(input logic [SZ_W-1:0] code);
    return OCC_W'(16) << code;
  endfunction
endpackage

// File: rtl/qsi_flag_gen.sv
module qsi_flag_gen
  import qsi_pkg::*;
(
  input  logic [OCC_W-1:0] occ_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [WM_W-1:0]  ne_wm_i,
  input  logic [WM_W-1:0]  nf_wm_i,
  output qflags_t          flags_o
);
  logic [OCC_W-1:0] cap, free;

  always_comb begin
    cap             = cap_entries(size_i);
    free            = (occ_i >= cap) ? '0 : cap - occ_i;
    flags_o.empty   = (occ_i == '0);
    flags_o.full    = (occ_i >= cap);
    flags_o.nempty  = (occ_i <= wm_thresh(ne_wm_i));
    flags_o.nfull   = (free <= wm_thresh(nf_wm_i));
  end
endmodule

// File: rtl/qsi_irq_bank.sv
module qsi_irq_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] cond_q, pend_q, rise;

  assign rise = cond_i & ~cond_q & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= '0;
      pend_q <= '0;
    end else begin
      cond_q <= cond_i;
      pend_q <= (pend_q & ~clr_i) | rise;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  assert_set_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(en_i)) == '0));

  assert_set_on_rising_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & ~$past(pend_o) & $past(cond_q)) == '0));

  assert_w1c_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_o & $past(clr_i) & ~$past(cond_i & ~cond_q)) == '0));

  assert_pending_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pend_o & $past(pend_o) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/qstat_irq.sv
module qstat_irq
  import qsi_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2*BANK_W*OCC_W-1:0]   occ_i,
  input  logic [2*BANK_W*SZ_W-1:0]    size_i,
  input  logic [2*BANK_W*WM_W-1:0]    ne_wm_i,
  input  logic [2*BANK_W*WM_W-1:0]    nf_wm_i,
  input  logic                        reg_we_i,
  input  logic [3:0]                  reg_addr_i,
  input  logic [DATA_W-1:0]           reg_wdata_i,
  output logic [DATA_W-1:0]           reg_rdata_o,
  output logic                        irq_lo_o,
  output logic                        irq_hi_o
);
  localparam int N_Q       = 2 * BANK_W;
  localparam int LO_WORDS  = BANK_W / Q_PER_WORD;
  localparam int A_UNE     = LO_WORDS;
  localparam int A_UF      = LO_WORDS + 1;
  localparam int A_PEND_LO = LO_WORDS + 2;
  localparam int A_PEND_HI = LO_WORDS + 3;
  localparam int A_EN_LO   = LO_WORDS + 4;
  localparam int A_EN_HI   = LO_WORDS + 5;
  localparam int A_SEL     = LO_WORDS + 6;
  localparam int ADDR_W    = 4;

  qflags_t flags [N_Q];

  for (genvar q = 0; q < N_Q; q++) begin : g_flags
    qsi_flag_gen u_fg (
      .occ_i   (occ_i[q*OCC_W +: OCC_W]),
      .size_i  (size_i[q*SZ_W +: SZ_W]),
      .ne_wm_i (ne_wm_i[q*WM_W +: WM_W]),
      .nf_wm_i (nf_wm_i[q*WM_W +: WM_W]),
      .flags_o (flags[q])
    );

    assert_empty_not_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(flags[q].empty && flags[q].full));
    assert_empty_implies_ne_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags[q].empty |-> flags[q].nempty);
    assert_full_implies_nf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags[q].full |-> flags[q].nfull);
  end

  // configuration registers
  logic [SEL_W-1:0]  sel_q [BANK_W];
  logic [BANK_W-1:0] en_lo_q, en_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_lo_q <= '0;
      en_hi_q <= '0;
      for (int q = 0; q < BANK_W; q++) sel_q[q] <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(A_EN_LO)) en_lo_q <= reg_wdata_i[BANK_W-1:0];
      if (reg_addr_i == ADDR_W'(A_EN_HI)) en_hi_q <= reg_wdata_i[BANK_W-1:0];
      for (int k = 0; k < LO_WORDS; k++) begin
        if (reg_addr_i == ADDR_W'(A_SEL + k)) begin
          for (int j = 0; j < Q_PER_WORD; j++)
            sel_q[k*Q_PER_WORD + j] <= reg_wdata_i[j*FIELD_W +: SEL_W];
        end
      end
    end
  end

  // interrupt conditions
  logic [BANK_W-1:0] cond_lo, cond_hi, une_vec, uf_vec;

  for (genvar q = 0; q < BANK_W; q++) begin : g_cond
    logic pick;
    always_comb begin
      unique case (src_e'(sel_q[q][1:0]))
        SRC_EMPTY:  pick = flags[q].empty;
        SRC_NEMPTY: pick = flags[q].nempty;
        SRC_NFULL:  pick = flags[q].nfull;
        default:    pick = flags[q].full;
      endcase
    end
    assign cond_lo[q] = pick ^ sel_q[q][2];
    assign une_vec[q] = flags[BANK_W+q].nempty;
    assign uf_vec[q]  = flags[BANK_W+q].full;
    assign cond_hi[q] = flags[BANK_W+q].nempty;
  end

  // pending banks
  logic [BANK_W-1:0] clr_lo, clr_hi, pend_lo, pend_hi;

  assign clr_lo = (reg_we_i && reg_addr_i == ADDR_W'(A_PEND_LO)) ? reg_wdata_i[BANK_W-1:0] : '0;
  assign clr_hi = (reg_we_i && reg_addr_i == ADDR_W'(A_PEND_HI)) ? reg_wdata_i[BANK_W-1:0] : '0;

  qsi_irq_bank #(.W(BANK_W)) u_bank_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (cond_lo),
    .en_i   (en_lo_q),
    .clr_i  (clr_lo),
    .pend_o (pend_lo),
    .irq_o  (irq_lo_o)
  );

  qsi_irq_bank #(.W(BANK_W)) u_bank_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (cond_hi),
    .en_i   (en_hi_q),
    .clr_i  (clr_hi),
    .pend_o (pend_hi),
    .irq_o  (irq_hi_o)
  );

  // read path
  logic [DATA_W-1:0] st_word  [LO_WORDS];
  logic [DATA_W-1:0] sel_word [LO_WORDS];

  for (genvar k = 0; k < LO_WORDS; k++) begin : g_words
    always_comb begin
      st_word[k]  = '0;
      sel_word[k] = '0;
      for (int j = 0; j < Q_PER_WORD; j++) begin
        st_word[k][j*FIELD_W +: FIELD_W]  = flags[k*Q_PER_WORD + j];
        sel_word[k][j*FIELD_W +: SEL_W]   = sel_q[k*Q_PER_WORD + j];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < LO_WORDS; k++) begin
      if (reg_addr_i == ADDR_W'(k))         reg_rdata_o = st_word[k];
      if (reg_addr_i == ADDR_W'(A_SEL + k)) reg_rdata_o = sel_word[k];
    end
    if (reg_addr_i == ADDR_W'(A_UNE))     reg_rdata_o = DATA_W'(une_vec);
    if (reg_addr_i == ADDR_W'(A_UF))      reg_rdata_o = DATA_W'(uf_vec);
    if (reg_addr_i == ADDR_W'(A_PEND_LO)) reg_rdata_o = DATA_W'(pend_lo);
    if (reg_addr_i == ADDR_W'(A_PEND_HI)) reg_rdata_o = DATA_W'(pend_hi);
    if (reg_addr_i == ADDR_W'(A_EN_LO))   reg_rdata_o = DATA_W'(en_lo_q);
    if (reg_addr_i == ADDR_W'(A_EN_HI))   reg_rdata_o = DATA_W'(en_hi_q);
  end

  assert_sel_bit3_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= ADDR_W'(A_SEL)) |-> ((reg_rdata_o & 32'h8888_8888) == '0));

  assert_irq_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_lo_o) |-> ($past(en_lo_q) != '0));
endmodule

// File: tb/sim_qstat_irq.sv
`timescale 1ns/1ps
module sim_qstat_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] occ [64];
  logic [1:0] sz  [64];
  logic [2:0] nec [64];
  logic [2:0] nfc [64];

  logic [511:0] occ_v;
  logic [127:0] sz_v;
  logic [191:0] ne_v, nf_v;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  always_comb begin
    for (int q = 0; q < 64; q++) begin
      occ_v[q*8 +: 8] = occ[q];
      sz_v[q*2 +: 2]  = sz[q];
      ne_v[q*3 +: 3]  = nec[q];
      nf_v[q*3 +: 3]  = nfc[q];
    end
  end

  qstat_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .occ_i(occ_v), .size_i(sz_v),
    .ne_wm_i(ne_v), .nf_wm_i(nf_v), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // reference state
  logic [2:0]  msel [32];
  logic [31:0] men0, men1, mp0, mp1;
  logic [63:0] mcprev;

  function automatic logic [3:0] mflags(int q);
    int cap, t_ne, t_nf, free;
    logic [3:0] f;
    cap  = 16 << sz[q];
    t_ne = (nec[q] == 0) ? 0 : (1 << (nec[q] - 1));
    t_nf = (nfc[q] == 0) ? 0 : (1 << (nfc[q] - 1));
    free = (occ[q] >= cap) ? 0 : cap - occ[q];
    f[0] = (occ[q] == 0);
    f[1] = (occ[q] <= t_ne);
    f[2] = (free <= t_nf);
    f[3] = (occ[q] >= cap);
    return f;
  endfunction

  function automatic logic mcond(int q);
    logic [3:0] f;
    f = mflags(q);
    if (q < 32) return f[msel[q][1:0]] ^ msel[q][2];
    return f[1];
  endfunction

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w = '0;
    if (a < 4) for (int j = 0; j < 8; j++) w[j*4 +: 4] = mflags(a*8 + j);
    else if (a == 4) for (int j = 0; j < 32; j++) w[j] = mflags(32 + j)[1];
    else if (a == 5) for (int j = 0; j < 32; j++) w[j] = mflags(32 + j)[3];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    logic [63:0] c;
    logic [31:0] k0, k1, np0, np1;
    for (int q = 0; q < 64; q++) c[q] = mcond(q);
    k0 = (we && addr == 4'd6) ? wdata : '0;
    k1 = (we && addr == 4'd7) ? wdata : '0;
    np0 = (mp0 & ~k0) | (c[31:0] & ~mcprev[31:0] & men0);
    np1 = (mp1 & ~k1) | (c[63:32] & ~mcprev[63:32] & men1);
    @(posedge clk);
    mp0 = np0; mp1 = np1; mcprev = c;
    if (we) begin
      if (addr == 4'd8) men0 = wdata;
      if (addr == 4'd9) men1 = wdata;
      if (addr >= 4'd10 && addr <= 4'd13)
        for (int j = 0; j < 8; j++) msel[(addr - 10)*8 + j] = wdata[j*4 +: 3];
    end
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
  endtask

  task automatic chk_pend(string req);
    logic [31:0] d;
    rd(4'd6, d); check(req, d, mp0);
    rd(4'd7, d); check(req, d, mp1);
    check({req, " irq_lo R9"}, {31'd0, irq_lo}, {31'd0, mp0 != 0});
    check({req, " irq_hi R9"}, {31'd0, irq_hi}, {31'd0, mp1 != 0});
  endtask

  task automatic chk_status(string req);
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(4'(a), d);
      check(req, d, exp_word(a));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    void'($urandom(32'd20240517));
    for (int q = 0; q < 64; q++) begin
      occ[q] = 8'd30; sz[q] = 2'd2; nec[q] = 3'd3; nfc[q] = 3'd3;
    end
    for (int q = 0; q < 32; q++) msel[q] = '0;
    men0 = '0; men1 = '0; mp0 = '0; mp1 = '0; mcprev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int a = 6; a < 14; a++) begin
      rd(4'(a), d); check("R10 reset register", d, 32'd0);
    end
    check("R10 irq lines", {30'd0, irq_hi, irq_lo}, 32'd0);

    // R1/R2/R3 directed flags
    occ[9] = 0; sz[9] = 0; nec[9] = 0; nfc[9] = 0;
    rd(4'd1, d); check("R1 queue 9 nibble empty", (d >> 4) & 32'hF, 32'h3);
    occ[9] = 16;
    rd(4'd1, d); check("R2 queue 9 full at capacity", (d >> 4) & 32'hF, 32'hC);
    occ[9] = 200;
    rd(4'd1, d); check("R2 queue 9 over capacity", (d >> 4) & 32'hF, 32'hC);
    sz[12] = 0; nec[12] = 3; nfc[12] = 3;
    occ[12] = 4;  rd(4'd1, d); check("R3 ne boundary occ=4", (d >> 16) & 32'hF, 32'h2);
    occ[12] = 5;  rd(4'd1, d); check("R3 above both marks", (d >> 16) & 32'hF, 32'h0);
    occ[12] = 12; rd(4'd1, d); check("R3 nf boundary free=4", (d >> 16) & 32'hF, 32'h4);
    occ[40] = 2; nec[40] = 2; occ[41] = 64;
    rd(4'd4, d); check("R4 upper ne bit 8", d & 32'h300, 32'h100);
    rd(4'd5, d); check("R4 upper full bit 9", d & 32'h300, 32'h200);
    chk_status("R1 R4 directed status");

    // R11 status writes ignored
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd4, 32'hFFFF_FFFF);
    chk_status("R11 status after write");

    // R5 source select, bit 3 protected
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, d); check("R5 sel bit3 reads 0", d, 32'h7777_7777);
    wr(4'd10, 32'h0000_0000);
    rd(4'd10, d); check("R5 sel cleared", d, 32'h0);

    // R7 rising edge with enable
    occ[5] = 3; tick();
    wr(4'd8, 32'h0000_0020);
    occ[5] = 0; tick();
    rd(4'd6, d); check("R7 pending on empty edge", d, 32'h20);
    chk_pend("R7 directed");
    // R7 no set while disabled, and not on late enable
    occ[6] = 0; tick();
    wr(4'd8, 32'h0000_0060); tick();
    rd(4'd6, d); check("R7 late enable no set", d, 32'h20);
    // R11 disabling enable keeps pending
    wr(4'd8, 32'h0);
    rd(4'd6, d); check("R11 pending kept after disable", d, 32'h20);
    // R8 clear exactly seen bits
    wr(4'd6, 32'h20);
    rd(4'd6, d); check("R8 w1c clear", d, 32'h0);
    check("R9 irq_lo low", {31'd0, irq_lo}, 32'd0);
    // R5 inverted source: not-empty on queue 7
    wr(4'd10, 32'h4000_0000);
    wr(4'd8, 32'h80);
    occ[7] = 0; tick();
    occ[7] = 5; tick();
    rd(4'd6, d); check("R5 inverted condition", d & 32'h80, 32'h80);
    // R8 set wins over simultaneous clear
    occ[7] = 0; tick();
    occ[7] = 6; wr(4'd6, 32'h80);
    rd(4'd6, d); check("R8 set beats clear", d & 32'h80, 32'h80);
    chk_pend("R8 directed");
    // R6 upper fixed to nearly empty
    wr(4'd9, 32'h4);
    occ[34] = 64; tick();
    rd(4'd7, d); check("R6 full does not interrupt", d, 32'h0);
    occ[34] = 1; tick();
    rd(4'd7, d); check("R6 nearly empty interrupts", d, 32'h4);
    check("R9 irq_hi high", {31'd0, irq_hi}, 32'd1);

    // random status rounds
    for (int rnd = 0; rnd < 20; rnd++) begin
      for (int q = 0; q < 64; q++) begin
        sz[q]  = 2'($urandom_range(0, 3));
        nec[q] = 3'($urandom_range(0, 7));
        nfc[q] = 3'($urandom_range(0, 7));
        occ[q] = 8'($urandom_range(0, 16 << sz[q]));
      end
      chk_status("R1 R2 R3 R4 random status");
    end

    // random interrupt traffic
    for (int k = 0; k < 4; k++) wr(4'(10 + k), $urandom() & 32'h7777_7777);
    wr(4'd8, $urandom()); wr(4'd9, $urandom());
    for (int t = 0; t < 400; t++) begin
      for (int n = 0; n < 4; n++) begin
        int q;
        q = $urandom_range(0, 63);
        occ[q] = 8'($urandom_range(0, 16 << sz[q]));
      end
      if (t % 8 == 7) begin
        rd(4'($urandom_range(6, 7)), r);
        wr(addr, r);
      end else if (t % 50 == 49) begin
        wr(4'($urandom_range(8, 9)), $urandom());
      end else begin
        tick();
      end
      chk_pend("R7 R8 R9 random pending");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule